// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the responding side of a synchronous bus on which one set of lines carries first an address and then data, in the manner of PCI. An initiator opens a transaction by raising `frame` while it presents a byte address on `ad_in` and a command on `cbe`. On the next clock the target decides whether the address falls in its window and the command is one it serves. If both hold, it claims the transaction and runs one or more data phases against a small word-addressed register store inside the block.

During data phases the same `cbe` lines act as per-lane byte enables. Each completed phase advances to the next word. The initiator marks its final phase by dropping `frame`. On reads the target leaves the lines undriven for one turnaround clock before it places data on them. The shared lines are modelled as a separate input bus, output bus and output enable, so a pad ring or an on-chip mux can merge them.

Top module: `mux_ad_target`

## Requirements
- R1: After a synchronous active-low reset, `claim`, `trdy` and `ad_oe` are low, `ad_out` is zero and every stored word reads back as zero.
- R2: A transaction starts only on a clock edge where `frame` is high and was low at the previous edge, while the target is idle. The address and command are sampled at that edge. A command that changes while `frame` stays high opens nothing.
- R3: The target claims an access only when the byte address bits above the 64-word, 256-byte window (bits 31 down to 8) equal those of the `BASE_ADDR` parameter. The word index is taken from address bits 7 down to 2. For an address outside the window, `claim`, `trdy` and `ad_oe` stay low for the whole transaction and the store is unchanged.
- R4: Command code 4'b0110 is a read and 4'b0111 is a write. Every other code leaves the target idle and the store unchanged.
- R5: `claim` rises on the clock after the address phase and stays high until the last data phase completes. `ad_oe` is never high without `claim`.
- R6: On a read, the clock after the address phase is a turnaround clock with `claim` high and `ad_oe` and `trdy` low. From the next clock, `ad_oe` and `trdy` are high and `ad_out` carries the addressed word.
- R7: On a write, `trdy` is high from the clock right after the address phase.
- R8: A data phase completes only at an edge where `irdy` and `trdy` are both high. While `irdy` is low, read data holds steady and nothing is written.
- R9: On a completed write phase, byte lane i (bits 8i+7 down to 8i) of the word is updated exactly when `cbe[i]` is 1. The other lanes keep their old value.
- R10: Each completed phase that is not the last advances the word index by one. The index wraps from 63 to 0 inside the window.
- R11: At the clock after a phase completes with `frame` low, `claim`, `trdy` and `ad_oe` are all low and the target accepts a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame | input | 1 | Transaction framing from the initiator; low in the final data phase |
| irdy | input | 1 | Initiator ready for the current data phase |
| ad_in | input | 32 | Shared lines as seen by the target: address, then write data |
| cbe | input | 4 | Command during the address phase, byte enables (1 = lane valid) during data phases |
| ad_out | output | 32 | Read data that the target places on the shared lines |
| ad_oe | output | 1 | Target drives the shared lines this clock |
| trdy | output | 1 | Target ready for the current data phase |
| claim | output | 1 | Target has accepted the current transaction |

## Verification
The embedded properties assume a well-behaved initiator. It keeps `frame` high until the clock in which it also raises `irdy` for its final phase, it never lowers `frame` while a phase is still waiting, and its inputs are never unknown after reset. The bench's transaction tasks build every access so that this holds. `frame` falls only together with a ready last phase, idle clocks return `frame` and `irdy` low, and any deliberate misbehaviour, such as changing the command with `frame` held high, is limited to transactions the target must ignore.

// File: rtl/mad_pkg.sv
// Shared definitions for the multiplexed address/data target.
// Assumes a 4-bit command field whose codes are fixed by the bus protocol.
package mad_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TURN  = 2'd1,
        ST_RDATA = 2'd2,
        ST_WDATA = 2'd3
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/mad_window_decode.sv
// Address window decoder: compares the upper address bits against an aligned
// base and extracts the word index inside the window.
// Assumes WORDS is a power of two and BASE_ADDR is aligned to WORDS*4 bytes.
module mad_window_decode #(
    parameter int                BUS_W     = 32,
    parameter int                WORDS     = 64,
    parameter logic [BUS_W-1:0]  BASE_ADDR = 32'h0000_4000
) (
    input  logic [BUS_W-1:0]              addr,
    output logic                          hit,
    output logic [$clog2(WORDS)-1:0]      word_idx
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int LOW   = IDX_W + 2;

    logic unused_byte_offset;

    // Window match on everything above the word index.
    always_comb begin
        hit = (addr[BUS_W-1:LOW] == BASE_ADDR[BUS_W-1:LOW]);
    end

    // Word index within the window; byte offset bits play no part.
    always_comb begin
        word_idx           = addr[LOW-1:2];
        unused_byte_offset = ^addr[1:0];
    end
endmodule

// File: rtl/mad_burst_ctrl.sv
// Transaction sequencer: detects the start of a transaction, decides whether
// to claim it, inserts the read turnaround, and steps the word index per
// completed data phase until the initiator signals the last phase.
// Assumes the initiator holds frame high until the clock of its final phase.
module mad_burst_ctrl
    import mad_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame,
    input  logic             irdy,
    input  logic [3:0]       cmd,
    input  logic             hit,
    input  logic [IDX_W-1:0] start_idx,
    output logic             claim,
    output logic             trdy,
    output logic             drive,
    output logic             wr_en,
    output logic [IDX_W-1:0] widx
);
    tgt_state_e state;
    logic       frame_q;
    logic       start;
    logic       phase_done;

    // A new transaction opens on a rising frame seen while idle.
    always_comb begin
        start      = (state == ST_IDLE) && frame && !frame_q;
        phase_done = trdy && irdy;
    end

    // Decoded outputs of the sequencer state.
    always_comb begin
        claim = (state != ST_IDLE);
        trdy  = (state == ST_RDATA) || (state == ST_WDATA);
        drive = (state == ST_RDATA);
        wr_en = (state == ST_WDATA) && irdy;
    end

    // State, word index and frame history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            widx    <= '0;
            frame_q <= 1'b0;
        end else begin
            frame_q <= frame;
            case (state)
                ST_IDLE: begin
                    if (start && hit && cmd == CMD_MEM_RD) begin
                        state <= ST_TURN;
                        widx  <= start_idx;
                    end else if (start && hit && cmd == CMD_MEM_WR) begin
                        state <= ST_WDATA;
                        widx  <= start_idx;
                    end
                end
                ST_TURN: begin
                    state <= ST_RDATA;
                end
                ST_RDATA, ST_WDATA: begin
                    if (phase_done) begin
                        widx <= widx + 1'b1;
                        if (!frame) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_window_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !hit) |=> !claim);

    assert_unknown_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cmd != CMD_MEM_RD && cmd != CMD_MEM_WR) |=> !claim);

    assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim && frame_q) |=> !claim);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> ($past(claim) && !$past(drive) && !$past(trdy)));

    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && !irdy) |=> ($stable(widx) && trdy));

    assert_burst_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && irdy && frame) |=> (widx == IDX_W'($past(widx) + 1'b1)));

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && irdy && !frame) |=> (!claim && !trdy && !drive));
endmodule

// File: rtl/mad_byte_regs.sv
// Word-addressed register store with one asynchronous read port and one
// byte-enabled write port, built as one storage slice per byte lane.
// Assumes DATA_W is a multiple of eight; cleared by synchronous reset.
module mad_byte_regs #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(WORDS)-1:0]  wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [DATA_W/8-1:0]       wr_be,
    input  logic [$clog2(WORDS)-1:0]  rd_idx,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        // Update this lane only when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) begin
                    lane_mem[w] <= 8'h00;
                end
            end else if (wr_en && wr_be[g]) begin
                lane_mem[wr_idx] <= wr_data[8*g +: 8];
            end
        end

        // Combinational read of this lane.
        always_comb begin
            rd_data[8*g +: 8] = lane_mem[rd_idx];
        end
    end
endmodule

// File: rtl/mux_ad_target.sv
// Top of the multiplexed address/data bus target: ties the window decoder,
// the transaction sequencer and the byte-lane store together and presents
// the shared lines as separate input, output and output-enable.
// Assumes a single initiator that obeys the frame/irdy rules of the bus.
module mux_ad_target #(
    parameter int                BUS_W     = 32,
    parameter int                WORDS     = 64,
    parameter logic [BUS_W-1:0]  BASE_ADDR = 32'h0000_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame,
    input  logic              irdy,
    input  logic [BUS_W-1:0]  ad_in,
    input  logic [3:0]        cbe,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic              trdy,
    output logic              claim
);
    localparam int IDX_W = $clog2(WORDS);

    logic             hit;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] widx;
    logic             drive;
    logic             wr_en;
    logic [BUS_W-1:0] rd_data;

    mad_window_decode #(
        .BUS_W     (BUS_W),
        .WORDS     (WORDS),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr     (ad_in),
        .hit      (hit),
        .word_idx (start_idx)
    );

    mad_burst_ctrl #(
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame     (frame),
        .irdy      (irdy),
        .cmd       (cbe),
        .hit       (hit),
        .start_idx (start_idx),
        .claim     (claim),
        .trdy      (trdy),
        .drive     (drive),
        .wr_en     (wr_en),
        .widx      (widx)
    );

    mad_byte_regs #(
        .DATA_W (BUS_W),
        .WORDS  (WORDS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (widx),
        .wr_data (ad_in),
        .wr_be   (cbe),
        .rd_idx  (widx),
        .rd_data (rd_data)
    );

    // Put read data on the lines only in a driving clock; zero otherwise.
    always_comb begin
        ad_oe  = drive;
        ad_out = drive ? rd_data : '0;
    end

    assert_drive_claimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> claim);

    assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !irdy) |=> (ad_oe && $stable(ad_out)));
endmodule

// File: tb/sim_mux_ad_target.sv
module sim_mux_ad_target;
    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam logic [3:0]  RD   = 4'b0110;
    localparam logic [3:0]  WR   = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame = 1'b0;
    logic        irdy = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe = '0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic        trdy;
    logic        claim;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [64];

    always #2 clk = ~clk;

    mux_ad_target #(.BUS_W(32), .WORDS(64), .BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .frame(frame), .irdy(irdy), .ad_in(ad_in),
        .cbe(cbe), .ad_out(ad_out), .ad_oe(ad_oe), .trdy(trdy), .claim(claim)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
        return (32'(i) * 32'h9E37_79B9) ^ salt;
    endfunction

    function automatic logic [31:0] waddr(input int idx);
        return BASE | (32'(idx % 64) << 2);
    endfunction

    task automatic check_idle(input string tag);
        chk(!claim && !trdy && !ad_oe, tag, {29'd0, claim, trdy, ad_oe}, 32'd0);
    endtask

    task automatic write_burst(input int idx0, input int n, input logic [31:0] salt,
                               input logic [3:0] be, input logic [31:0] wmask);
        frame = 1'b1; ad_in = waddr(idx0); cbe = WR; irdy = 1'b0;
        tick();
        chk(claim && trdy && !ad_oe, "R5/R7 write claim", {29'd0, claim, trdy, ad_oe}, 32'd6);
        for (int i = 0; i < n; i++) begin
            if (wmask[i % 32]) begin
                irdy = 1'b0; ad_in = 32'hDEAD_BEEF; cbe = 4'hF; frame = 1'b1;
                tick();
            end
            irdy = 1'b1; ad_in = pat(i, salt); cbe = be; frame = (i != n - 1);
            tick();
            for (int l = 0; l < 4; l++) begin
                if (be[l]) model[(idx0 + i) % 64][8*l +: 8] = pat(i, salt) >> (8 * l);
            end
            if (i != n - 1) chk(claim && trdy, "R5 claim held in burst", {31'd0, claim}, 32'd1);
        end
        check_idle("R11 write release");
        frame = 1'b0; irdy = 1'b0; ad_in = '0; cbe = '0;
    endtask

    task automatic read_burst(input int idx0, input int n, input logic [31:0] wmask, input string tag);
        frame = 1'b1; ad_in = waddr(idx0); cbe = RD; irdy = 1'b0;
        tick();
        chk(claim && !ad_oe && !trdy, "R6 turnaround", {29'd0, claim, trdy, ad_oe}, 32'd4);
        ad_in = '0; cbe = 4'hF;
        tick();
        for (int i = 0; i < n; i++) begin
            chk(ad_oe && trdy, "R6 drive", {30'd0, ad_oe, trdy}, 32'd3);
            chk(ad_out == model[(idx0 + i) % 64], tag, ad_out, model[(idx0 + i) % 64]);
            if (wmask[i % 32]) begin
                irdy = 1'b0;
                tick();
                chk(ad_oe && ad_out == model[(idx0 + i) % 64], "R8 read wait hold", ad_out, model[(idx0 + i) % 64]);
            end
            irdy = 1'b1; frame = (i != n - 1);
            tick();
        end
        check_idle("R11 read release");
        frame = 1'b0; irdy = 1'b0;
    endtask

    task automatic ignored(input logic [31:0] addr, input logic [3:0] cmd, input string tag);
        frame = 1'b1; ad_in = addr; cbe = cmd; irdy = 1'b0;
        tick();
        for (int k = 0; k < 3; k++) begin
            check_idle(tag);
            irdy = 1'b1; ad_in = 32'h1234_5678; cbe = 4'hF; frame = (k != 2);
            tick();
        end
        check_idle(tag);
        frame = 1'b0; irdy = 1'b0; ad_in = '0; cbe = '0;
        tick();
    endtask

    initial begin
        for (int w = 0; w < 64; w++) model[w] = '0;
        frame = 1'b1; irdy = 1'b1; cbe = WR; ad_in = BASE;
        repeat (3) tick();
        frame = 1'b0; irdy = 1'b0; cbe = '0; ad_in = '0;
        tick();
        check_idle("R1 reset outputs");
        chk(ad_out == 32'd0, "R1 reset data", ad_out, 32'd0);
        rst_n = 1'b1;
        tick();
        check_idle("R1 idle after reset");
        read_burst(0, 64, 32'h0, "R1 cleared store");

        // Full window sweep with waits on both sides of the handshake (R8, R10).
        write_burst(0, 64, 32'hA5C3_0F11, 4'hF, 32'h0000_0005);
        read_burst(0, 64, 32'h0000_0012, "R10 burst readback");
        read_burst(17, 5, 32'h0, "R10 offset burst");

        // Byte enable sweep over all sixteen lane patterns (R9).
        for (int b = 0; b < 16; b++) begin
            write_burst(20 + b, 1, 32'h0BAD_F00D + 32'(b), 4'(b), 32'h0);
            read_burst(20 + b, 1, 32'h0, "R9 byte lanes");
        end

        // Index wrap inside the window (R10).
        write_burst(62, 4, 32'h7777_1234, 4'hF, 32'h0000_0002);
        read_burst(61, 6, 32'h0000_0001, "R10 wrap");

        // Misses and unsupported commands leave everything untouched (R3, R4).
        ignored(BASE + 32'h100, WR, "R3 miss above window");
        ignored(BASE - 32'h4, WR, "R3 miss below window");
        ignored(BASE ^ 32'h8000_0000, RD, "R3 miss high bit");
        for (int c = 0; c < 16; c++) begin
            if (4'(c) != RD && 4'(c) != WR) ignored(waddr(c), 4'(c), "R4 unknown command");
        end
        read_burst(0, 64, 32'h0, "R3/R4 store unchanged");

        // Command swapped while frame stays high opens nothing (R2).
        frame = 1'b1; ad_in = waddr(5); cbe = 4'b0010; irdy = 1'b0;
        tick();
        cbe = WR; ad_in = waddr(5);
        tick();
        check_idle("R2 no start on held frame");
        irdy = 1'b1; ad_in = 32'hFFFF_FFFF; cbe = 4'hF; frame = 1'b0;
        tick();
        check_idle("R2 no start on held frame");
        irdy = 1'b0;
        // Back-to-back write then read straight after release (R2, R7).
        write_burst(5, 2, 32'h1357_2468, 4'hF, 32'h0);
        read_burst(5, 2, 32'h0, "R2 back-to-back");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule